// File: doc/BRIEF.md
# Pulse Swallow Divider

The block divides a VCO clock down to a comparison pulse `fp_o` using a dual-modulus prescaler followed by two counters. The prescaler is behavioural and runs on the VCO clock. Its base modulus P is 128 or 256, and it divides by P+1 while the modulus control line is high.

At the start of every output cycle the swallow counter reloads with A and the main counter reloads with N. While the swallow counter is non-zero, the prescaler runs at P+1. After that it runs at P until the main counter has seen N prescaler outputs. The total division is therefore P·N + A.

New settings are taken in with a load strobe into a pending copy. The running copy is replaced only at an output cycle boundary, so no output period mixes old and new settings.

Top module: `pulse_swallow_div`

## Requirements
- R1: With A ≤ N, successive rising edges of `fp_o` are exactly P·N + A clock cycles apart, where A is `swallow_i` and N is `main_i` (16..2047).
- R2: `mod_sel_i` = 1 selects P = 128 (128/129) and `mod_sel_i` = 0 selects P = 256 (256/257).
- R3: In each output cycle, `mod_ctl_o` is high for the first A prescaler outputs, which is A·(P+1) clock cycles starting at the rising edge of `fp_o`. It is low for the rest of the cycle.
- R4: With A = 0, `mod_ctl_o` stays low for the whole output cycle and the period is P·N.
- R5: `fp_o` rises at the end of each completed output cycle and stays high for exactly one prescaler output period. That is P+1 clock cycles when A > 0 and P when A = 0.
- R6: A load strobe captures A, N and the modulus select. The captured values govern only the output cycle that starts at the next boundary. If several loads occur within one cycle, the last one wins and the earlier ones have no effect.
- R7: `cfg_err_o` is high throughout any output cycle whose A exceeds N. In such a cycle `mod_ctl_o` stays high for the whole cycle and the period is N·(P+1).
- R8: During and after reset `fp_o`, `mod_ctl_o` and `cfg_err_o` are low. The block starts with A = 0, N = 16 and P = 128, so the first `fp_o` rising edge comes 2048 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe; captures the three settings into the pending copy |
| swallow_i | input | 8 | Swallow count A (0..255) |
| main_i | input | 11 | Main count N (16..2047) |
| mod_sel_i | input | 1 | Prescaler base: 1 selects 128/129, 0 selects 256/257 |
| fp_o | output | 1 | Comparison pulse, one prescaler period wide |
| mod_ctl_o | output | 1 | Modulus control; high selects P+1 |
| cfg_err_o | output | 1 | High while the running A exceeds N |

## Verification
The assertions assume that every load carries N of at least 16 and that the clock runs continuously. They also assume that the running settings change only at a boundary, which is what lets the prescaler and the modulus line be checked tick by tick. The stimulus keeps N between 16 and 260 so that each period stays short. Loads are placed a cycle after a boundary or well inside a cycle, and in some cycles a decoy is overwritten before the real value. The measured periods, modulus-high counts and pulse widths are compared against values computed per interval from the settings the bench itself loaded.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int SW_W = 8;
  localparam int MN_W = 11;

  typedef struct packed {
    logic            sel;
    logic [SW_W-1:0] a;
    logic [MN_W-1:0] n;
  } cfg_t;
endpackage

// File: rtl/psd_cfg.sv
module psd_cfg
  import psd_pkg::*;
#(
  parameter int N_RST   = 16,
  parameter int A_RST   = 0,
  parameter bit SEL_RST = 1'b1,
  parameter int N_MIN   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SW_W-1:0] a_i,
  input  logic [MN_W-1:0] n_i,
  input  logic            sel_i,
  input  logic            bnd_i,
  output cfg_t            nxt_o,
  output cfg_t            act_o,
  output logic            err_o
);
  cfg_t pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q.sel <= SEL_RST;
      pend_q.a   <= SW_W'(A_RST);
      pend_q.n   <= MN_W'(N_RST);
      act_q.sel  <= SEL_RST;
      act_q.a    <= SW_W'(A_RST);
      act_q.n    <= MN_W'(N_RST);
    end else begin
      if (load_i) begin
        pend_q.sel <= sel_i;
        pend_q.a   <= a_i;
        pend_q.n   <= n_i;
      end
      // running copy swaps only at a cycle boundary
      if (bnd_i) act_q <= pend_q;
    end
  end

  assign nxt_o = pend_q;
  assign act_o = act_q;
  assign err_o = MN_W'(act_q.a) > act_q.n;

  // input assumption: loads stay inside the legal N range
  a_r1_main_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (n_i >= MN_W'(N_MIN)));

  a_r6_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bnd_i) |-> $stable(act_q));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P_LO = 128,
  parameter int P_HI = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic mod_i,
  output logic tick_o
);
  localparam int PC_W = $clog2(P_HI + 2);

  logic [PC_W-1:0] cnt_q, last;

  assign last   = (sel_i ? PC_W'(P_LO) : PC_W'(P_HI)) + PC_W'(mod_i) - PC_W'(1);
  assign tick_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PC_W'(1);
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/psd_counters.sv
module psd_counters
  import psd_pkg::*;
#(
  parameter int N_RST = 16,
  parameter int A_RST = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  cfg_t nxt_i,
  output logic bnd_o,
  output logic mod_o,
  output logic fp_o
);
  logic [SW_W-1:0] sw_q;
  logic [MN_W-1:0] mn_q;
  logic            fp_q;

  assign bnd_o = tick_i && (mn_q == MN_W'(1));
  assign mod_o = (sw_q != '0);
  assign fp_o  = fp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q <= SW_W'(A_RST);
      mn_q <= MN_W'(N_RST);
      fp_q <= 1'b0;
    end else if (tick_i) begin
      if (bnd_o) begin
        sw_q <= nxt_i.a;
        mn_q <= nxt_i.n;
        fp_q <= 1'b1;
      end else begin
        mn_q <= mn_q - MN_W'(1);
        if (sw_q != '0) sw_q <= sw_q - SW_W'(1);
        fp_q <= 1'b0;
      end
    end
  end

  a_r3_mod_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(mod_o));
  a_r5_fp_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fp_o) |-> $past(bnd_o));
  a_r5_fp_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fp_o) |-> $past(tick_i));
  a_r1_main_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mn_q != '0);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int P_LO  = 128,
  parameter int P_HI  = 256,
  parameter int N_RST = 16,
  parameter int A_RST = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SW_W-1:0] swallow_i,
  input  logic [MN_W-1:0] main_i,
  input  logic            mod_sel_i,
  output logic            fp_o,
  output logic            mod_ctl_o,
  output logic            cfg_err_o
);
  cfg_t nxt, act;
  logic bnd, tick, mod;

  psd_cfg #(.N_RST(N_RST), .A_RST(A_RST), .SEL_RST(1'b1), .N_MIN(16)) u_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .a_i   (swallow_i), .n_i(main_i), .sel_i(mod_sel_i),
    .bnd_i (bnd), .nxt_o(nxt), .act_o(act), .err_o(cfg_err_o)
  );

  psd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(act.sel), .mod_i(mod), .tick_o(tick)
  );

  psd_counters #(.N_RST(N_RST), .A_RST(A_RST)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .nxt_i(nxt),
    .bnd_o(bnd), .mod_o(mod), .fp_o(fp_o)
  );

  assign mod_ctl_o = mod;
endmodule

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [7:0]  swallow_i = '0;
  logic [10:0] main_i = 11'd16;
  logic        mod_sel_i = 1'b1;
  logic        fp_o, mod_ctl_o, cfg_err_o;

  pulse_swallow_div uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .swallow_i(swallow_i),
    .main_i(main_i), .mod_sel_i(mod_sel_i), .fp_o(fp_o),
    .mod_ctl_o(mod_ctl_o), .cfg_err_o(cfg_err_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    int per;
    int hi;
    int fw;
    int err;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int c_sel[8] = '{1, 1, 0, 1, 1, 0, 1, 1};
  int c_a[8]   = '{0, 5, 3, 16, 20, 0, 255, 7};
  int c_n[8]   = '{16, 16, 16, 16, 16, 17, 260, 17};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input int sel, input int a, input int n);
    @(negedge clk_i);
    load_i    = 1'b1;
    mod_sel_i = sel[0];
    swallow_i = a[7:0];
    main_i    = n[10:0];
    @(negedge clk_i);
    load_i    = 1'b0;
  endtask

  // expected figures for one output cycle from the requirements
  function automatic exp_t model(input int sel, input int a, input int n);
    exp_t e;
    int p, s;
    p = sel ? 128 : 256;          // R2
    s = (a <= n) ? a : n;         // R7 truncation
    e.per = p * n + s;            // R1
    e.hi  = s * (p + 1);          // R3, R4
    e.fw  = (s > 0) ? p + 1 : p;  // R5
    e.err = (a > n) ? 1 : 0;      // R7
    return e;
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor: measures each fp interval and compares with the scoreboard
  initial begin
    bit prev, started;
    int cnt, hi, fw, err_s, since_rst;
    exp_t e;
    prev = 0; started = 0; cnt = 0; hi = 0; fw = 0; err_s = 0; since_rst = 0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      since_rst++;
      if (fp_o && !prev) begin
        if (!started) begin
          chk("R8", "first fp delay", since_rst, 2048);
          started = 1;
        end else if (q.size() == 0) begin
          chk("R1", "scoreboard empty", 0, 1);
        end else begin
          e = q.pop_front();
          chk("R1", "period", cnt, e.per);
          chk("R3", "mod_ctl high cycles", hi, e.hi);
          chk("R5", "fp width", fw, e.fw);
          chk("R7", "cfg_err", err_s, e.err);
        end
        cnt = 1; hi = int'(mod_ctl_o); fw = 1; err_s = int'(cfg_err_o);
      end else begin
        cnt++;
        hi += int'(mod_ctl_o);
        fw += int'(fp_o);
        if (cfg_err_o) err_s = 1;
      end
      prev = fp_o;
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8", "fp in reset", int'(fp_o), 0);
    chk("R8", "mod_ctl in reset", int'(mod_ctl_o), 0);
    chk("R8", "cfg_err in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R8", "mod_ctl after reset", int'(mod_ctl_o), 0);
    chk("R8", "fp after reset", int'(fp_o), 0);
    do_load(c_sel[0], c_a[0], c_n[0]);
    for (int i = 0; i < 8; i++) begin
      @(posedge fp_o);
      q.push_back(model(c_sel[i], c_a[i], c_n[i]));
      if (i + 1 < 8) begin
        if (i % 2 == 1) begin
          // R6: decoy overwritten later in the same cycle
          do_load(0, 200, 2000);
          repeat (40) @(negedge clk_i);
        end
        do_load(c_sel[i + 1], c_a[i + 1], c_n[i + 1]);
      end
    end
    @(posedge fp_o);
    repeat (2) @(negedge clk_i);
    chk("R6", "scoreboard drained", q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule